// File: doc/BRIEF.md
# Strobed Host Register Interface

This block is the parallel host access port of a time-slot switch. A microprocessor reaches a control register and, through a 32-location address window, one of three switch memories: the data memory (readable by the host), the low half of the connection memory, and the high half. The host bus is asynchronous. It has an active-low chip select, an active-high data strobe, a read/write line, six address lines and an 8-bit data bus. The block brings the handshake lines into the 4.096 MHz switch clock domain through a two-stage synchronizer. It decodes the address. Memory accesses wait for an access slot that the switching core grants.

Completion is reported on an open-drain acknowledge. The block only ever pulls this line low, and an external resistor pulls it high. The data bus is split into an input path, an output path and a drive enable, and the pad ring combines them into the bidirectional pins. The control register chooses which memory the window maps to and which serial stream within it. The 32 window addresses then select the channel within that stream.

Top module: `host_strobe_port`

## Requirements
- R1: `hst_cs_n`, `hst_ds` and `hst_rd_wr` pass through a two-stage synchronizer. An access that needs no memory slot raises `hst_ack_pull` exactly 3 clock cycles after the strobe (with chip select low) is applied.
- R2: Address 0x00 is an 8-bit control register that is readable and writable in full and resets to 0x00. Bit 4 set selects the connection memory, and then bit 3 chooses the high half (1) or the low half (0). Bit 4 clear selects the data memory. Bits [1:0] choose the stream.
- R3: Addresses 0x20–0x3F form the memory window. `mem_addr` is {stream bits [1:0], address[4:0]}. `mem_sel` encodes data memory as 0, connection-low as 1 and connection-high as 2, so each half and each stream holds separate contents.
- R4: A window access raises `mem_req` and holds it until `mem_grant` arrives. The acknowledge is raised only in the cycle after the grant. Read data is the `mem_rdata` value present in the grant cycle.
- R5: `hst_ack_pull` falls exactly 3 clock cycles after the strobe or chip select is withdrawn. It never stays high for more than one cycle after the synchronized access has ended.
- R6: `hst_d_oe` is high only while chip select is low, the strobe is high and `hst_rd_wr` is 1 (read). `hst_d_o` carries the read result once the acknowledge is set.
- R7: A host write into the window while the data memory is selected raises no memory request. It is still acknowledged, and the data memory keeps its contents.
- R8: Addresses 0x01–0x1F are unmapped. Reads return 0x00, writes change nothing, and neither raises a memory request. Both are acknowledged.
- R9: If the strobe is withdrawn before the grant, the request is dropped, no memory access takes place and no acknowledge is given.
- R10: If the grant arrives in the same cycle in which the synchronized strobe falls, the access completes (a write reaches memory), but no acknowledge is raised.
- R11: During and after reset, `hst_ack_pull`, `mem_req` and `hst_d_oe` (with chip select high) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz switch clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_ds | input | 1 | Host data strobe, active high |
| hst_rd_wr | input | 1 | 1 = read, 0 = write |
| hst_addr | input | 6 | Host address |
| hst_d_i | input | 8 | Write data from the bus pads |
| hst_d_o | output | 8 | Read data toward the bus pads |
| hst_d_oe | output | 1 | Bus pad drive enable |
| hst_ack_pull | output | 1 | 1 = pull the open-drain acknowledge low |
| mem_req | output | 1 | Request for a memory access slot |
| mem_grant | input | 1 | Slot granted this cycle |
| mem_we | output | 1 | Slot is a write |
| mem_sel | output | 2 | Target memory (0 data, 1 conn-low, 2 conn-high) |
| mem_addr | output | 7 | Stream and channel address |
| mem_wdata | output | 8 | Write data for the slot |
| mem_rdata | input | 8 | Read data from the selected memory in the grant cycle |

## Verification
Two events can fall on the same clock edge: the core's slot grant and the withdrawal of the synchronized host strobe. The bench provokes this by dropping the strobe as soon as a write request appears, then holding back the grant so that it lands exactly on the edge where the synchronized strobe falls. It judges the result in two ways. The written byte must appear in the bench's memory model, and the acknowledge must stay low throughout. A separate run withholds the grant completely and expects the request to be dropped without any write.

// File: rtl/hri_pkg.sv
package hri_pkg;
  localparam int HRI_DATA_W  = 8;
  localparam int HRI_ADDR_W  = 6;
  localparam int HRI_CHAN_W  = 5;
  localparam int HRI_STRM_W  = 2;
  localparam int HRI_MADDR_W = HRI_STRM_W + HRI_CHAN_W;
  localparam int CTRL_CONN_BIT = 4;
  localparam int CTRL_HALF_BIT = 3;

  typedef enum logic [1:0] {
    TGT_DATA    = 2'd0,
    TGT_CONN_LO = 2'd1,
    TGT_CONN_HI = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } eng_st_e;

  function automatic tgt_e target_of(input logic [HRI_DATA_W-1:0] c);
    if (!c[CTRL_CONN_BIT]) return TGT_DATA;
    return c[CTRL_HALF_BIT] ? TGT_CONN_HI : TGT_CONN_LO;
  endfunction

  function automatic logic [HRI_MADDR_W-1:0] win_addr(input logic [HRI_DATA_W-1:0] c,
                                                      input logic [HRI_ADDR_W-1:0] a);
    return {c[HRI_STRM_W-1:0], a[HRI_CHAN_W-1:0]};
  endfunction

  function automatic logic is_window(input logic [HRI_ADDR_W-1:0] a);
    return a[HRI_ADDR_W-1];
  endfunction

  function automatic logic is_ctrl(input logic [HRI_ADDR_W-1:0] a);
    return a == '0;
  endfunction
endpackage

// File: rtl/hri_sync.sv
module hri_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hri_engine.sv
module hri_engine
  import hri_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   act_s,
  input  logic                   rd_s,
  input  logic [HRI_ADDR_W-1:0]  addr,
  input  logic [HRI_DATA_W-1:0]  wdata,
  input  logic                   mem_grant,
  input  logic [HRI_DATA_W-1:0]  mem_rdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [1:0]             mem_sel,
  output logic [HRI_MADDR_W-1:0] mem_addr,
  output logic [HRI_DATA_W-1:0]  mem_wdata,
  output logic                   ack_pull,
  output logic [HRI_DATA_W-1:0]  rd_q
);
  eng_st_e                st;
  logic [HRI_DATA_W-1:0]  ctrl_q;
  logic                   m_we;
  tgt_e                   m_sel;
  logic [HRI_MADDR_W-1:0] m_addr;
  logic [HRI_DATA_W-1:0]  m_wd;

  tgt_e tgt;
  logic go_mem;
  logic host_start;
  logic grant_taken;
  logic abort_pending;

  assign tgt           = target_of(ctrl_q);
  assign go_mem        = is_window(addr) && !(!rd_s && tgt == TGT_DATA);
  assign host_start    = (st == ST_IDLE) && act_s;
  assign grant_taken   = mem_req && mem_grant;
  assign abort_pending = mem_req && !act_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ctrl_q <= '0;
      rd_q   <= '0;
      m_we   <= 1'b0;
      m_sel  <= TGT_DATA;
      m_addr <= '0;
      m_wd   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (host_start) begin
          if (go_mem) begin
            st     <= ST_WAIT;
            m_we   <= ~rd_s;
            m_sel  <= tgt;
            m_addr <= win_addr(ctrl_q, addr);
            m_wd   <= wdata;
          end else begin
            st <= ST_ACK;
            if (is_ctrl(addr)) begin
              if (rd_s) rd_q   <= ctrl_q;
              else      ctrl_q <= wdata;
            end else if (rd_s) begin
              rd_q <= '0;
            end
          end
        end
        ST_WAIT: begin
          if (grant_taken) begin
            if (!m_we) rd_q <= mem_rdata;
            st <= act_s ? ST_ACK : ST_IDLE;
          end else if (abort_pending) begin
            st <= ST_IDLE;
          end
        end
        ST_ACK: if (!act_s) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == ST_WAIT);
  assign ack_pull  = (st == ST_ACK);
  assign mem_we    = m_we;
  assign mem_sel   = m_sel;
  assign mem_addr  = m_addr;
  assign mem_wdata = m_wd;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_grant && act_s |=> mem_req); // R4
  AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull && $past(mem_req) |-> $past(mem_grant)); // R4
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull && !act_s |=> !ack_pull); // R5
  AST_NO_DMEM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !(mem_we && mem_sel == TGT_DATA)); // R7
  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pending && !mem_grant |=> !mem_req && !ack_pull); // R9
  AST_COLLIDE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    grant_taken && !act_s |=> !ack_pull); // R10
endmodule

// File: rtl/host_strobe_port.sv
module host_strobe_port
  import hri_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hst_cs_n,
  input  logic                   hst_ds,
  input  logic                   hst_rd_wr,
  input  logic [HRI_ADDR_W-1:0]  hst_addr,
  input  logic [HRI_DATA_W-1:0]  hst_d_i,
  output logic [HRI_DATA_W-1:0]  hst_d_o,
  output logic                   hst_d_oe,
  output logic                   hst_ack_pull,
  output logic                   mem_req,
  input  logic                   mem_grant,
  output logic                   mem_we,
  output logic [1:0]             mem_sel,
  output logic [HRI_MADDR_W-1:0] mem_addr,
  output logic [HRI_DATA_W-1:0]  mem_wdata,
  input  logic [HRI_DATA_W-1:0]  mem_rdata
);
  logic [2:0] raw_hs;
  logic [2:0] syn_hs;
  logic       act_s;
  logic       rd_s;

  assign raw_hs = {hst_cs_n, hst_ds, hst_rd_wr};

  hri_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_hs), .q(syn_hs)
  );

  assign act_s = ~syn_hs[2] & syn_hs[1];
  assign rd_s  = syn_hs[0];

  hri_engine u_eng (
    .clk(clk), .rst_n(rst_n), .act_s(act_s), .rd_s(rd_s),
    .addr(hst_addr), .wdata(hst_d_i),
    .mem_grant(mem_grant), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ack_pull(hst_ack_pull), .rd_q(hst_d_o)
  );

  assign hst_d_oe = ~hst_cs_n & hst_ds & hst_rd_wr;
endmodule

// File: tb/host_strobe_port_tb.sv
module host_strobe_port_tb_top;
  localparam int CLK_PERIOD = 244;
  localparam int NVEC = 18;
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 6'h00, 8'h11, 8'h00}, {1'b0, 6'h25, 8'hA5, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'hA5}, {1'b0, 6'h00, 8'h19, 8'h00},
    {1'b0, 6'h25, 8'h3C, 8'h00}, {1'b1, 6'h25, 8'h00, 8'h3C},
    {1'b1, 6'h00, 8'h00, 8'h19}, {1'b0, 6'h00, 8'h11, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'hA5}, {1'b0, 6'h00, 8'h12, 8'h00},
    {1'b1, 6'h25, 8'h00, 8'h00}, {1'b0, 6'h00, 8'h02, 8'h00},
    {1'b1, 6'h30, 8'h00, 8'h0A}, {1'b0, 6'h30, 8'hFF, 8'h00},
    {1'b1, 6'h30, 8'h00, 8'h0A}, {1'b1, 6'h05, 8'h00, 8'h00},
    {1'b0, 6'h05, 8'hEE, 8'h00}, {1'b1, 6'h00, 8'h00, 8'h02}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ds = 1'b0, rd_wr = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] d_i = '0, d_o;
  logic d_oe, ack_pull, mem_req, mem_grant = 1'b0, mem_we;
  logic [1:0] mem_sel;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] dmem [128], clo [128], chi [128];
  logic auto_gnt = 1'b1, ack_seen = 1'b0;
  int gcnt = 0, grants = 0, n_tests = 0, n_fail = 0;
  logic [7:0] exp_ctrl = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_strobe_port dut_i (
    .clk(clk), .rst_n(rst_n), .hst_cs_n(cs_n), .hst_ds(ds), .hst_rd_wr(rd_wr),
    .hst_addr(addr), .hst_d_i(d_i), .hst_d_o(d_o), .hst_d_oe(d_oe),
    .hst_ack_pull(ack_pull), .mem_req(mem_req), .mem_grant(mem_grant),
    .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial for (int i = 0; i < 128; i++) begin
    dmem[i] = 8'(i) ^ 8'h5A; clo[i] = 8'h00; chi[i] = 8'h00;
  end

  always_comb
    case (mem_sel)
      2'd1: mem_rdata = clo[mem_addr];
      2'd2: mem_rdata = chi[mem_addr];
      default: mem_rdata = dmem[mem_addr];
    endcase

  always @(posedge clk) if (mem_req && mem_grant) begin
    grants <= grants + 1;
    if (mem_we)
      case (mem_sel)
        2'd1: clo[mem_addr] <= mem_wdata;
        2'd2: chi[mem_addr] <= mem_wdata;
        default: dmem[mem_addr] <= mem_wdata;
      endcase
  end

  always @(negedge clk) begin
    if (ack_pull) ack_seen = 1'b1;
    if (auto_gnt) begin
      if (mem_req && !mem_grant) begin
        if (gcnt >= 2) begin mem_grant = 1'b1; gcnt = 0; end
        else gcnt++;
      end else mem_grant = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rw, input logic [5:0] a, input logic [7:0] wd,
                      output logic [7:0] rd, output int lat, output int rel, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; ds = 1'b1; rd_wr = rw; addr = a; d_i = wd;
    lat = 0;
    while (!ack_pull && lat < 200) begin @(negedge clk); lat++; end
    rd = d_o; oe = d_oe;
    ds = 1'b0; cs_n = 1'b1;
    rel = 0;
    while (ack_pull && rel < 200) begin @(negedge clk); rel++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    int lat, rel, g0;
    logic oe;
    repeat (3) @(negedge clk);
    check("R11 ack in reset", ack_pull, 0);
    check("R11 req in reset", mem_req, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 ack after reset", ack_pull, 0);
    check("R11 req after reset", mem_req, 0);
    check("R11 oe idle", d_oe, 0);

    cs_n = 1'b1; ds = 1'b1; rd_wr = 1'b1; #1;
    check("R6 oe cs high", d_oe, 0);
    cs_n = 1'b0; ds = 1'b0; #1;
    check("R6 oe ds low", d_oe, 0);
    cs_n = 1'b1; rd_wr = 1'b0;

    xfer(1'b1, 6'h00, 8'h00, rd, lat, rel, oe);
    check("R2 ctrl reset value", rd, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      logic rw; logic [5:0] a; logic [7:0] wd, ex; logic memx;
      {rw, a, wd, ex} = VEC[v];
      memx = a[5] && !(!rw && !exp_ctrl[4]);
      g0 = grants;
      xfer(rw, a, wd, rd, lat, rel, oe);
      if (rw) check(a == 0 ? "R2 ctrl read" : (a[5] ? "R3 window read" : "R8 unmapped read"), rd, ex);
      check("R6 oe during access", oe, rw);
      check(memx ? "R4 grant count" : "R7 R8 no slot", grants - g0, memx ? 1 : 0);
      if (memx) check("R4 ack after grant", lat > 3, 1);
      else      check("R1 sync latency", lat, 3);
      check("R5 release latency", rel, 3);
      if (!rw && a == 0) exp_ctrl = wd;
    end
    check("R7 dmem kept", dmem[80], 8'h0A);

    // R9 abandon before grant
    xfer(1'b0, 6'h00, 8'h11, rd, lat, rel, oe);
    auto_gnt = 1'b0; mem_grant = 1'b0;
    @(negedge clk); ack_seen = 1'b0;
    cs_n = 1'b0; ds = 1'b1; rd_wr = 1'b0; addr = 6'h2B; d_i = 8'h99;
    while (!mem_req) @(negedge clk);
    ds = 1'b0; cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 req dropped", mem_req, 0);
    check("R9 no ack", ack_seen, 0);
    check("R9 no write", clo[7'h2B], 8'h00);

    // R10 grant on the edge the synced strobe falls
    ack_seen = 1'b0;
    cs_n = 1'b0; ds = 1'b1; rd_wr = 1'b0; addr = 6'h2A; d_i = 8'h77;
    while (!mem_req) @(negedge clk);
    ds = 1'b0; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    mem_grant = 1'b1;
    @(negedge clk); mem_grant = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 write landed", clo[7'h2A], 8'h77);
    check("R10 no ack", ack_seen, 0);
    check("R10 req released", mem_req, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule